// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two IEEE 754 operands in half, single or double precision, or one operand against positive zero. It produces a four-bit condition code and an invalid-operation indication. The code goes into the top nibble of a 32-bit status image that the block holds. The invalid indication is accumulated in a sticky bit of that same image. A compare is issued with a one-cycle `valid_i` strobe. Narrower formats are taken from the low bits of the 64-bit operand buses, and the rest of each bus is ignored.

Software-visible state is limited to the status image. An explicit write through `stat_we_i`/`stat_wdata_i` loads the whole image, and this write is the only way to clear the sticky bit. An illegal format select raises a one-cycle undefined-operation pulse and leaves the image untouched.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: `size_i` selects the format: 2'b01 is half precision taken from operand bits [15:0], 2'b10 is single precision taken from [31:0], and 2'b11 is double precision taken from [63:0]. Operand bits above the selected width have no effect.
- R2: A compare with `size_i` = 2'b00 gives `undef_o` = 1 in the next cycle and `inv_o` = 0, and it leaves `stat_o` unchanged.
- R3: When `zero_mode_i` = 1, the second operand is positive zero of the selected width, and `opb_i` has no effect on the flags or on the invalid indication.
- R4: If either operand is a NaN (all-ones exponent, nonzero fraction), the code is unordered: N,Z,C,V = 0,0,1,1.
- R5: For ordered operands, the code is 1000 when operand A is less than operand B, 0110 when they are equal, and 0010 when A is greater.
- R6: Positive and negative zero compare equal. Subnormal values compare by their true magnitude and are not flushed to zero.
- R7: When both operands are negative, the one with the larger magnitude is the smaller value.
- R8: A signaling NaN (top fraction bit 0) in either operand always raises the invalid indication.
- R9: A quiet NaN (top fraction bit 1) raises the invalid indication only when `qnan_sig_i` = 1. Otherwise it gives the unordered code with no exception.
- R10: The code is written to `stat_o[31:28]` in the order N,Z,C,V. Bits [27:1] are unchanged by a compare.
- R11: `stat_o[0]` is sticky. A compare ORs its invalid indication into this bit. Only a write with `stat_we_i` = 1 loads the whole image, and such a write has priority over a compare in the same cycle, whose status update is dropped.
- R12: The status image, `undef_o` and `inv_o` update on the clock edge that samples `valid_i`. `undef_o` and `inv_o` are one-cycle pulses. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Issue a compare this cycle |
| size_i | input | 2 | Format select (01 half, 10 single, 11 double, 00 illegal) |
| zero_mode_i | input | 1 | Compare operand A against +0 |
| qnan_sig_i | input | 1 | Quiet NaN also raises invalid |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| stat_we_i | input | 1 | Load status image |
| stat_wdata_i | input | 32 | Status image write data |
| stat_o | output | 32 | Status image (code in [31:28], sticky invalid in [0]) |
| undef_o | output | 1 | Illegal format pulse |
| inv_o | output | 1 | Invalid-operation pulse for the last compare |

## Verification
On every cycle, the assertions check four properties. An illegal select freezes the image. A legal compare leaves only one of the four defined codes in the nibble, and it leaves the middle bits alone. The sticky bit never drops without a write, and it is set whenever an invalid pulse appears.

Only the bench's scenarios can show that the code chosen is the right one for given operands. This covers signed zeros, subnormals, negative ordering, NaN classes under both quiet-NaN settings, zero mode ignoring operand B, and garbage above the selected width. To do this, the bench compares each compare against a reference model built on real-number arithmetic.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int OP_W      = 64;
  localparam int STAT_W    = 32;
  localparam int CODE_LSB  = 28;
  localparam int STICKY_B  = 0;
  localparam int MAG_W     = OP_W - 1;
  localparam int N_FMT     = 3;

  typedef enum logic [1:0] {
    SZ_BAD  = 2'b00,
    SZ_HALF = 2'b01,
    SZ_SNGL = 2'b10,
    SZ_DBL  = 2'b11
  } fsize_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             qnan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } fclass_t;

  localparam logic [3:0] CODE_LT = 4'b1000;
  localparam logic [3:0] CODE_EQ = 4'b0110;
  localparam logic [3:0] CODE_GT = 4'b0010;
  localparam logic [3:0] CODE_UN = 4'b0011;

  function automatic int fmt_exp_w(int idx);
    return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
  endfunction

  function automatic int fmt_frac_w(int idx);
    return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
  endfunction
endpackage

// File: rtl/fpcmp_fmt_unpack.sv
module fpcmp_fmt_unpack
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOP   = EXP_W + FRAC_W
) (
  input  logic [TOP:0] op_i,
  output fclass_t      cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              is_nan;

  assign exp_f   = op_i[TOP-1 -: EXP_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign is_nan  = exp_max & (|frac_f);

  assign cls_o.sign = op_i[TOP];
  assign cls_o.nan  = is_nan;
  assign cls_o.qnan = is_nan & frac_f[FRAC_W-1];
  assign cls_o.snan = is_nan & ~frac_f[FRAC_W-1];
  assign cls_o.zero = ~|op_i[TOP-1:0];
  // exponent:fraction as unsigned orders magnitudes, subnormals included
  assign cls_o.mag  = MAG_W'(op_i[TOP-1:0]);
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fclass_t    cls_a_i,
  input  fclass_t    cls_b_i,
  input  logic       qnan_sig_i,
  output logic [3:0] code_o,
  output logic       invalid_o
);
  logic any_nan, both_zero, mag_lt, mag_eq;

  assign any_nan   = cls_a_i.nan | cls_b_i.nan;
  assign both_zero = cls_a_i.zero & cls_b_i.zero;
  assign mag_lt    = cls_a_i.mag < cls_b_i.mag;
  assign mag_eq    = cls_a_i.mag == cls_b_i.mag;

  always_comb begin
    if (any_nan)                          code_o = CODE_UN;
    else if (both_zero)                   code_o = CODE_EQ;
    else if (cls_a_i.sign != cls_b_i.sign) code_o = cls_a_i.sign ? CODE_LT : CODE_GT;
    else if (mag_eq)                      code_o = CODE_EQ;
    else if (mag_lt ^ cls_a_i.sign)       code_o = CODE_LT;
    else                                  code_o = CODE_GT;
  end

  assign invalid_o = cls_a_i.snan | cls_b_i.snan
                   | (qnan_sig_i & (cls_a_i.qnan | cls_b_i.qnan));
endmodule

// File: rtl/fpcmp_status.sv
module fpcmp_status
  import fpcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [3:0]        code_i,
  input  logic              invalid_i,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (we_i) begin
      stat_q <= wdata_i;
    end else if (upd_i) begin
      stat_q[CODE_LSB +: 4] <= code_i;
      stat_q[STICKY_B]      <= stat_q[STICKY_B] | invalid_i;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
  import fpcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic              zero_mode_i,
  input  logic              qnan_sig_i,
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              undef_o,
  output logic              inv_o
);
  logic [OP_W-1:0] opb_eff;
  fclass_t         cls_a [N_FMT];
  fclass_t         cls_b [N_FMT];
  fclass_t         sel_a, sel_b;
  logic [3:0]      code;
  logic            invalid;
  logic            legal;
  logic            undef_q, inv_q;

  // +0 is all zeros in every width
  assign opb_eff = zero_mode_i ? '0 : opb_i;
  assign legal   = (size_i != SZ_BAD);

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int EW = fmt_exp_w(g);
    localparam int FW = fmt_frac_w(g);
    fpcmp_fmt_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unpack_a (
      .op_i (opa_i[EW+FW:0]),
      .cls_o(cls_a[g])
    );
    fpcmp_fmt_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unpack_b (
      .op_i (opb_eff[EW+FW:0]),
      .cls_o(cls_b[g])
    );
  end

  always_comb begin
    unique case (size_i)
      SZ_HALF: begin sel_a = cls_a[0]; sel_b = cls_b[0]; end
      SZ_SNGL: begin sel_a = cls_a[1]; sel_b = cls_b[1]; end
      default: begin sel_a = cls_a[2]; sel_b = cls_b[2]; end
    endcase
  end

  fpcmp_order u_order (
    .cls_a_i   (sel_a),
    .cls_b_i   (sel_b),
    .qnan_sig_i(qnan_sig_i),
    .code_o    (code),
    .invalid_o (invalid)
  );

  fpcmp_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (valid_i & legal),
    .code_i   (code),
    .invalid_i(invalid),
    .we_i     (stat_we_i),
    .wdata_i  (stat_wdata_i),
    .stat_o   (stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      undef_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      undef_q <= valid_i & ~legal;
      inv_q   <= valid_i & legal & invalid;
    end
  end

  assign undef_o = undef_q;
  assign inv_o   = inv_q;
endmodule

// File: rtl/fpcmp_flag_unit_chk.sv
module fpcmp_flag_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  size_i,
  input logic        stat_we_i,
  input logic [31:0] stat_wdata_i,
  input logic [31:0] stat_o,
  input logic        undef_o,
  input logic        inv_o
);
  p_undef_keeps_stat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == 2'b00 && !stat_we_i |=> $stable(stat_o));

  p_undef_no_inv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !inv_o);

  p_code_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i != 2'b00 && !stat_we_i |=>
      (stat_o[31:28] == 4'b1000 || stat_o[31:28] == 4'b0110 ||
       stat_o[31:28] == 4'b0010 || stat_o[31:28] == 4'b0011));

  p_mid_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> stat_o[27:1] == $past(stat_o[27:1]));

  p_sticky_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i && stat_o[0] |=> stat_o[0]);

  p_inv_sets_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !stat_we_i |=> (!inv_o || stat_o[0]));

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> stat_o == $past(stat_wdata_i));

  p_pulse_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_o || undef_o) |-> $past(valid_i));
endmodule

bind fpcmp_flag_unit fpcmp_flag_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .size_i      (size_i),
  .stat_we_i   (stat_we_i),
  .stat_wdata_i(stat_wdata_i),
  .stat_o      (stat_o),
  .undef_o     (undef_o),
  .inv_o       (inv_o)
);

// File: tb/tb_fpcmp_flag_unit.sv
`timescale 1ns/1ps
module tb_fpcmp_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        zm = 1'b0;
  logic        qs = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] stat;
  logic        undef;
  logic        inv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_stat = '0;
  logic        m_undef = 1'b0;
  logic        m_inv = 1'b0;

  always #4 clk = ~clk;

  fpcmp_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .size_i(size),
    .zero_mode_i(zm), .qnan_sig_i(qs), .opa_i(opa), .opb_i(opb),
    .stat_we_i(we), .stat_wdata_i(wd), .stat_o(stat), .undef_o(undef), .inv_o(inv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void decode(input logic [1:0] sz, input logic [63:0] x,
                                 output real v, output bit nan, output bit snan);
    int e;
    longint unsigned f;
    v = 0.0; nan = 0; snan = 0;
    case (sz)
      2'b01: begin
        e = int'(x[14:10]); f = longint'(x[9:0]);
        nan = (e == 31) && (f != 0); snan = nan && !x[9];
        if (e == 0) v = real'(f) * (2.0 ** (-24));
        else v = real'(f + 1024) * (2.0 ** (e - 25));
        if (x[15]) v = -v;
      end
      2'b10: begin
        e = int'(x[30:23]); f = longint'(x[22:0]);
        nan = (e == 255) && (f != 0); snan = nan && !x[22];
        if (e == 0) v = real'(f) * (2.0 ** (-149));
        else v = real'(f + 64'd8388608) * (2.0 ** (e - 150));
        if (x[31]) v = -v;
      end
      default: begin
        nan = (x[62:52] == 11'h7ff) && (x[51:0] != 0); snan = nan && !x[51];
        if (!nan) v = $bitstoreal(x);
      end
    endcase
  endfunction

  // reference model step: one compare/write cycle followed by an idle cycle
  task automatic op(input string tag, input bit v, input logic [1:0] sz, input bit z, input bit q,
                    input logic [63:0] a, input logic [63:0] b, input bit w, input logic [31:0] d);
    real ra, rb;
    bit na, sa, nb, sb, iv;
    logic [3:0] code;
    @(negedge clk);
    valid = v; size = sz; zm = z; qs = q; opa = a; opb = b; we = w; wd = d;
    m_undef = v && (sz == 2'b00);
    m_inv = 1'b0;
    if (v && sz != 2'b00) begin
      decode(sz, a, ra, na, sa);
      if (z) begin rb = 0.0; nb = 0; sb = 0; end
      else decode(sz, b, rb, nb, sb);
      iv = sa || sb || (q && (na || nb));
      if (na || nb) code = 4'b0011;
      else if (ra < rb) code = 4'b1000;
      else if (ra == rb) code = 4'b0110;
      else code = 4'b0010;
      m_inv = iv;
      if (!w) begin
        m_stat[31:28] = code;
        m_stat[0] = m_stat[0] | iv;
      end
    end
    if (w) m_stat = d;
    @(posedge clk);
    #1;
    valid = 1'b0; we = 1'b0;
    @(negedge clk);
    chk({tag, " stat"}, stat, m_stat);
    chk({tag, " undef"}, {31'd0, undef}, {31'd0, m_undef});
    chk({tag, " inv"}, {31'd0, inv}, {31'd0, m_inv});
  endtask

  function automatic logic [63:0] rnd_op(input logic [1:0] sz);
    logic [63:0] x;
    int k;
    x = {$urandom, $urandom};
    k = $urandom % 8;
    case (sz)
      2'b01: case (k)
        0: x[14:0] = '0;
        1: begin x[14:10] = '1; x[9] = 1'b1; end
        2: begin x[14:10] = '1; x[9] = 1'b0; x[0] = 1'b1; end
        3: x[14:10] = '0;
        default: ;
      endcase
      2'b10: case (k)
        0: x[30:0] = '0;
        1: begin x[30:23] = '1; x[22] = 1'b1; end
        2: begin x[30:23] = '1; x[22] = 1'b0; x[0] = 1'b1; end
        3: x[30:23] = '0;
        default: ;
      endcase
      default: case (k)
        0: x[62:0] = '0;
        1: begin x[62:52] = '1; x[51] = 1'b1; end
        2: begin x[62:52] = '1; x[51] = 1'b0; x[0] = 1'b1; end
        3: x[62:52] = '0;
        default: ;
      endcase
    endcase
    return x;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R12 act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset stat", stat, 32'h0);
    chk("R12 reset pulses", {30'd0, undef, inv}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R5 half lt, with garbage above bit 15
    op("R1 R5 half lt", 1, 2'b01, 0, 0, 64'hDEAD_BEEF_1234_3C00, 64'h5555_AAAA_9876_4000, 0, 0);
    op("R5 single eq", 1, 2'b10, 0, 0, 64'hFFFF_0000_3FC0_0000, 64'h0000_1111_3FC0_0000, 0, 0);
    op("R5 double gt", 1, 2'b11, 0, 0, 64'h4008_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 0);
    op("R7 neg double", 1, 2'b11, 0, 0, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0, 0);
    op("R7 neg half", 1, 2'b01, 0, 0, 64'h0000_0000_0000_BC00, 64'h0000_0000_0000_C000, 0, 0);
    op("R6 signed zeros", 1, 2'b01, 0, 0, 64'h8000, 64'h0000, 0, 0);
    op("R6 subnormal", 1, 2'b01, 0, 0, 64'h0001, 64'h0002, 0, 0);
    op("R6 sub vs zero", 1, 2'b10, 0, 0, 64'h8000_0001, 64'h0, 0, 0);
    op("R3 zero mode", 1, 2'b10, 1, 1, 64'hBF80_0000, 64'h7FC0_0000, 0, 0);
    op("R3 zero mode pos", 1, 2'b11, 1, 1, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 0, 0);
    op("R4 R9 qnan quiet", 1, 2'b10, 0, 0, 64'h7FC0_0000, 64'h3F80_0000, 0, 0);
    op("R11 write clear", 0, 2'b00, 0, 0, 0, 0, 1, 32'h0F0F_0F00);
    op("R9 qnan signals", 1, 2'b10, 0, 1, 64'h3F80_0000, 64'hFFC0_0000, 0, 0);
    op("R10 mid kept", 1, 2'b11, 0, 0, 64'h1, 64'h2, 0, 0);
    op("R11 write clear2", 0, 2'b00, 0, 0, 0, 0, 1, 32'h0000_0000);
    op("R8 snan double", 1, 2'b11, 0, 0, 64'h7FF0_0000_0000_0001, 64'h0, 0, 0);
    op("R8 snan half b", 1, 2'b01, 0, 0, 64'h3C00, 64'h7C01, 0, 0);
    op("R2 illegal size", 1, 2'b00, 0, 1, 64'h7FF0_0000_0000_0001, 64'h0, 0, 0);
    op("R11 write priority", 1, 2'b11, 0, 0, 64'h7FF0_0000_0000_0001, 64'h0, 1, 32'h1234_5670);
    op("R11 sticky kept", 1, 2'b11, 0, 0, 64'h1, 64'h1, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      logic [63:0] a, b;
      sz = 2'($urandom % 4);
      a = rnd_op(sz);
      b = ($urandom % 8 == 0) ? a : rnd_op(sz);
      op("R1 R4 R5 rand", 1, sz, ($urandom % 4) == 0, $urandom % 2, a, b,
         ($urandom % 16) == 0, $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule